// File: doc/BRIEF.md
# SPI Master Serial Clock and Select Timing Generator

This block produces the timing skeleton of one SPI master frame. A packed configuration word supplies the serial clock divider, the select-to-clock lead delay, the clock-to-deselect trail delay, the clock polarity and phase, the bit order and the frame length. The word is captured when a start pulse arrives. From then on, the block asserts chip select and holds the serial clock at its idle level for the lead delay. It then runs the programmed number of clock periods, holds the idle level again for the trail delay, releases chip select and raises a one-cycle done pulse.

A separate shift register does the data shifting. This block only tells that shifter when to sample the receive line and when to move the transmit line, through two strobes that are aligned with the clock edges. It also hands the shifter the captured bit order and bit count. The serial clock period in module clocks is a small prescaler factor times a scaler factor. Each delay is built the same way, from its own prescaler and scaler pair.

Top module: `sck_timing_gen`

## Requirements
- R1: The serial clock period P, in module clocks, is the product of two factors. The first is a baud prescaler chosen by cfg_word[17:16], where 0,1,2,3 give 2,3,5,7. The second is a baud scaler chosen by cfg_word[3:0]: codes 0 to 3 give 2,4,6,8 and a code n of 4 or more gives 2^n.
- R2: Each bit lasts P clocks. Its first half lasts P-floor(P/2) clocks and its second half lasts floor(P/2) clocks. With cfg_word[25]=0, SCK is at its idle level in the first half and at the active level in the second half. With cfg_word[25]=1 it is the other way round.
- R3: After the start edge, chip select is high and SCK stays idle for a lead delay of L clocks before the first bit begins. L = {1,3,5,7}[cfg_word[23:22]] * 2^(cfg_word[15:12]+1).
- R4: After the last bit, chip select stays high with SCK idle for a trail delay of T clocks. T = {1,3,5,7}[cfg_word[21:20]] * 2^(cfg_word[11:8]+1). Chip select is therefore high for L + N*P + T cycles in total.
- R5: The bit count N is cfg_word[30:27]+1. Field values below 3 are treated as 4, so N runs from 4 to 16. Each frame has exactly N sample strobes and N shift strobes.
- R6: SCK idles at the level of cfg_word[26]. While idle, SCK follows that bit of the input word one cycle later. During a frame, SCK returns to the captured level.
- R7: Each strobe is high in the same cycle as the SCK edge it marks. With cfg_word[25]=0, sample_stb marks the idle-to-active edges and shift_stb marks the active-to-idle edges. With cfg_word[25]=1 the assignment is swapped. The two strobes are never high together.
- R8: frame_done is a one-cycle pulse. It is high in the first cycle in which chip select is low again after a frame.
- R9: A start pulse during a frame is ignored. The configuration is captured only on the start edge, so changes to cfg_word during a frame have no effect on that frame.
- R10: lsb_first shows the captured cfg_word[24], and frame_bits shows the captured N, from the first cycle of the frame onwards.
- R11: After reset, chip select, SCK, both strobes and frame_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a frame when the block is idle |
| cfg_word | input | 31 | Packed clock and transfer attribute word |
| spi_sck | output | 1 | Serial clock |
| cs_active | output | 1 | Chip select, high while a frame is in progress |
| sample_stb | output | 1 | Marks the edge on which the receive line is sampled |
| shift_stb | output | 1 | Marks the edge on which the transmit line changes |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| lsb_first | output | 1 | Captured bit order for the shifter |
| frame_bits | output | 5 | Captured bit count for the shifter |

## Verification
The frame engine runs on random configuration words with a fixed seed. Each word mixes all four polarity and phase pairs, every frame-size code and small divider and delay codes. Measuring the first strobe position separates the lead delay from the half-period split. The total select length then pins the trail delay, and the length of the active SCK phase exposes any swap of the halves or of the phase assignment. Directed frames cover the minimum encoding, the clamped frame-size codes, a long divider, a large lead delay, and a start pulse plus a configuration change issued in the middle of a frame.

// File: rtl/sck_tgen_pkg.sv
package sck_tgen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_BITS  = 2'd2,
    ST_TRAIL = 2'd3
  } tgen_state_e;

  // baud prescaler: odd/prime divide factors
  function automatic int unsigned baud_pre_f(input logic [1:0] sel);
    case (sel)
      2'd0:    return 32'd2;
      2'd1:    return 32'd3;
      2'd2:    return 32'd5;
      default: return 32'd7;
    endcase
  endfunction

  // baud scaler: linear steps up to 8, then powers of two
  function automatic int unsigned baud_scl_f(input logic [3:0] sel);
    if (sel < 4'd4) return 32'd2 * (32'(sel) + 32'd1);
    return 32'd1 << sel;
  endfunction

  // delay prescaler: 1,3,5,7
  function automatic int unsigned dly_pre_f(input logic [1:0] sel);
    return 32'd2 * 32'(sel) + 32'd1;
  endfunction

  // delay scaler: 2^(n+1)
  function automatic int unsigned dly_scl_f(input logic [3:0] sel);
    return 32'd2 << sel;
  endfunction

endpackage

// File: rtl/sck_tgen_decode.sv
module sck_tgen_decode
  import sck_tgen_pkg::*;
#(
  parameter int CFG_W    = 31,
  parameter int CNT_W    = 20,
  parameter int BITS_W   = 5,
  parameter int MIN_BITS = 4
) (
  input  logic [CFG_W-1:0]  cfg,
  output logic [CNT_W-1:0]  lead_len,
  output logic [CNT_W-1:0]  trail_len,
  output logic [CNT_W-1:0]  half_a,
  output logic [CNT_W-1:0]  half_b,
  output logic [BITS_W-1:0] nbits,
  output logic              cpol,
  output logic              cpha,
  output logic              lsb
);
  localparam int FS_LO  = 27;
  localparam int POL_B  = 26;
  localparam int PHA_B  = 25;
  localparam int LSB_B  = 24;
  localparam int LPS_LO = 22;
  localparam int TPS_LO = 20;
  localparam int BPS_LO = 16;
  localparam int LSC_LO = 12;
  localparam int TSC_LO = 8;
  localparam int BSC_LO = 0;
  localparam logic [3:0] FS_CLAMP = 4'(MIN_BITS - 1);

  logic [CNT_W-1:0] period;
  logic [3:0]       fs;
  logic             unused_bits;

  assign unused_bits = ^{cfg[19:18], cfg[7:4]};

  assign period    = CNT_W'(baud_pre_f(cfg[BPS_LO+:2]) * baud_scl_f(cfg[BSC_LO+:4]));
  assign half_b    = period >> 1;
  assign half_a    = period - half_b;
  assign lead_len  = CNT_W'(dly_pre_f(cfg[LPS_LO+:2]) * dly_scl_f(cfg[LSC_LO+:4]));
  assign trail_len = CNT_W'(dly_pre_f(cfg[TPS_LO+:2]) * dly_scl_f(cfg[TSC_LO+:4]));

  assign fs    = cfg[FS_LO+:4];
  assign nbits = (fs < FS_CLAMP) ? BITS_W'(MIN_BITS) : BITS_W'(fs) + BITS_W'(1);
  assign cpol  = cfg[POL_B];
  assign cpha  = cfg[PHA_B];
  assign lsb   = cfg[LSB_B];
endmodule

// File: rtl/sck_tgen_count.sv
module sck_tgen_count #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sck_tgen_ctrl.sv
module sck_tgen_ctrl
  import sck_tgen_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int BITS_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  lead_len,
  input  logic [CNT_W-1:0]  trail_len,
  input  logic [CNT_W-1:0]  half_a,
  input  logic [CNT_W-1:0]  half_b,
  input  logic [BITS_W-1:0] nbits,
  input  logic              cpol_in,
  input  logic              cpha_in,
  input  logic              lsb_in,
  output logic              sck_q,
  output logic              cs_q,
  output logic              sample_q,
  output logic              shift_q,
  output logic              done_q,
  output logic              lsb_q,
  output logic [BITS_W-1:0] nb_q
);
  tgen_state_e      st, st_n;
  logic             seg, seg_n;
  logic [BITS_W-1:0] bl, bl_n;
  logic [CNT_W-1:0] ha_q, hb_q, tr_q, ld_val;
  logic             cpol_q, cpha_q;
  logic             ld, go, fin, zero;
  logic             pol_n, pha_n, sck_n, edge_n, lead_edge, samp_sel;

  sck_tgen_count #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .zero     (zero)
  );

  always_comb begin
    st_n   = st;
    seg_n  = seg;
    bl_n   = bl;
    ld     = 1'b0;
    ld_val = '0;
    go     = 1'b0;
    fin    = 1'b0;
    case (st)
      ST_IDLE: begin
        if (start) begin
          go     = 1'b1;
          st_n   = ST_LEAD;
          ld     = 1'b1;
          ld_val = lead_len - CNT_W'(1);
        end
      end
      ST_LEAD: begin
        if (zero) begin
          st_n   = ST_BITS;
          seg_n  = 1'b0;
          bl_n   = nb_q - BITS_W'(1);
          ld     = 1'b1;
          ld_val = ha_q - CNT_W'(1);
        end
      end
      ST_BITS: begin
        if (zero) begin
          ld = 1'b1;
          if (!seg) begin
            seg_n  = 1'b1;
            ld_val = hb_q - CNT_W'(1);
          end else if (bl == '0) begin
            st_n   = ST_TRAIL;
            ld_val = tr_q - CNT_W'(1);
          end else begin
            seg_n  = 1'b0;
            bl_n   = bl - BITS_W'(1);
            ld_val = ha_q - CNT_W'(1);
          end
        end
      end
      default: begin
        if (zero) begin
          st_n = ST_IDLE;
          fin  = 1'b1;
        end
      end
    endcase

    pol_n     = (st == ST_IDLE) ? cpol_in : cpol_q;
    pha_n     = (st == ST_IDLE) ? cpha_in : cpha_q;
    sck_n     = (st_n == ST_BITS) ? (pol_n ^ (pha_n ? ~seg_n : seg_n)) : pol_n;
    edge_n    = ((st == ST_BITS) || (st_n == ST_BITS)) && (sck_n != sck_q);
    lead_edge = (sck_n != pol_n);
    samp_sel  = lead_edge ^ pha_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      seg      <= 1'b0;
      bl       <= '0;
      ha_q     <= '0;
      hb_q     <= '0;
      tr_q     <= '0;
      nb_q     <= '0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      lsb_q    <= 1'b0;
      sck_q    <= 1'b0;
      cs_q     <= 1'b0;
      sample_q <= 1'b0;
      shift_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st       <= st_n;
      seg      <= seg_n;
      bl       <= bl_n;
      if (go) begin
        ha_q   <= half_a;
        hb_q   <= half_b;
        tr_q   <= trail_len;
        nb_q   <= nbits;
        cpol_q <= cpol_in;
        cpha_q <= cpha_in;
        lsb_q  <= lsb_in;
      end
      sck_q    <= sck_n;
      cs_q     <= (st_n != ST_IDLE);
      sample_q <= edge_n & samp_sel;
      shift_q  <= edge_n & ~samp_sel;
      done_q   <= fin;
    end
  end
endmodule

// File: rtl/sck_timing_gen.sv
module sck_timing_gen #(
  parameter int CFG_W    = 31,
  parameter int CNT_W    = 20,
  parameter int BITS_W   = 5,
  parameter int MIN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CFG_W-1:0]  cfg_word,
  output logic              spi_sck,
  output logic              cs_active,
  output logic              sample_stb,
  output logic              shift_stb,
  output logic              frame_done,
  output logic              lsb_first,
  output logic [BITS_W-1:0] frame_bits
);
  logic [CNT_W-1:0]  lead_len, trail_len, half_a, half_b;
  logic [BITS_W-1:0] nbits;
  logic              cpol, cpha, lsb;

  sck_tgen_decode #(
    .CFG_W(CFG_W), .CNT_W(CNT_W), .BITS_W(BITS_W), .MIN_BITS(MIN_BITS)
  ) u_dec (
    .cfg       (cfg_word),
    .lead_len  (lead_len),
    .trail_len (trail_len),
    .half_a    (half_a),
    .half_b    (half_b),
    .nbits     (nbits),
    .cpol      (cpol),
    .cpha      (cpha),
    .lsb       (lsb)
  );

  sck_tgen_ctrl #(.CNT_W(CNT_W), .BITS_W(BITS_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .lead_len  (lead_len),
    .trail_len (trail_len),
    .half_a    (half_a),
    .half_b    (half_b),
    .nbits     (nbits),
    .cpol_in   (cpol),
    .cpha_in   (cpha),
    .lsb_in    (lsb),
    .sck_q     (spi_sck),
    .cs_q      (cs_active),
    .sample_q  (sample_stb),
    .shift_q   (shift_stb),
    .done_q    (frame_done),
    .lsb_q     (lsb_first),
    .nb_q      (frame_bits)
  );
endmodule

// File: rtl/sck_tgen_checker.sv
module sck_tgen_checker (
  input logic clk,
  input logic rst,
  input logic start,
  input logic spi_sck,
  input logic cs_active,
  input logic sample_stb,
  input logic shift_stb,
  input logic frame_done
);
  assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sample_stb, shift_stb}));

  assert_strobe_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
    (sample_stb || shift_stb) |-> cs_active);

  assert_strobe_marks_edge_R7: assert property (@(posedge clk) disable iff (rst)
    (sample_stb || shift_stb) |-> (spi_sck != $past(spi_sck)));

  assert_sck_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (cs_active && $past(cs_active) && !sample_stb && !shift_stb) |-> $stable(spi_sck));

  assert_done_after_frame_R8: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (!cs_active && $past(cs_active)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  assert_start_only_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_active) |-> $past(start));
endmodule

bind sck_timing_gen sck_tgen_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .spi_sck    (spi_sck),
  .cs_active  (cs_active),
  .sample_stb (sample_stb),
  .shift_stb  (shift_stb),
  .frame_done (frame_done)
);

// File: tb/sck_timing_gen_test.sv
module sck_timing_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [30:0] cfg_word = '0;
  logic        spi_sck, cs_active, sample_stb, shift_stb, frame_done, lsb_first;
  logic [4:0]  frame_bits;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sck_timing_gen uut (
    .clk(clk), .rst(rst), .start(start), .cfg_word(cfg_word),
    .spi_sck(spi_sck), .cs_active(cs_active), .sample_stb(sample_stb),
    .shift_stb(shift_stb), .frame_done(frame_done), .lsb_first(lsb_first),
    .frame_bits(frame_bits)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int e_period(input logic [30:0] c);
    int pre, scl;
    pre = (c[17:16] == 2'd0) ? 2 : (c[17:16] == 2'd1) ? 3 : (c[17:16] == 2'd2) ? 5 : 7;
    scl = (c[3:0] < 4) ? 2 * (int'(c[3:0]) + 1) : (1 << c[3:0]);
    return pre * scl;
  endfunction

  function automatic int e_delay(input logic [1:0] p, input logic [3:0] s);
    return (2 * int'(p) + 1) * (1 << (int'(s) + 1));
  endfunction

  function automatic int e_bits(input logic [30:0] c);
    return (c[30:27] < 3) ? 4 : int'(c[30:27]) + 1;
  endfunction

  task automatic run_frame(input logic [30:0] c, input bit poke);
    int p, a, b, n, ld, tr, total, k, cs_cnt, first_edge, nsamp, nshift;
    int bad_pol, run, bad_run, run_exp, done_k, fe_exp;
    bit pol, pha;
    p = e_period(c); b = p / 2; a = p - b; n = e_bits(c);
    ld = e_delay(c[23:22], c[15:12]); tr = e_delay(c[21:20], c[11:8]);
    total = ld + n * p + tr;
    pol = c[26]; pha = c[25];
    run_exp = pha ? a : b;
    fe_exp  = pha ? ld : ld + a;
    cs_cnt = 0; first_edge = -1; nsamp = 0; nshift = 0;
    bad_pol = 0; run = 0; bad_run = 0; done_k = -1;

    @(negedge clk); cfg_word = c;
    @(negedge clk);
    chk(spi_sck == pol, "R6 idle level before frame", spi_sck, pol);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    k = 0;
    while (done_k < 0 && k < total + 50) begin
      if (k == 0) begin
        chk(cs_active == 1'b1, "R3 select at first cycle", cs_active, 1);
        chk(lsb_first == c[24], "R10 lsb_first", lsb_first, c[24]);
        chk(int'(frame_bits) == n, "R10/R5 frame_bits", frame_bits, n);
      end
      if (cs_active) cs_cnt++;
      if (sample_stb || shift_stb) begin
        if (first_edge < 0) first_edge = k;
        if (sample_stb) begin
          nsamp++;
          if ((spi_sck != pol) != !pha) bad_pol++;
        end
        if (shift_stb) nshift++;
      end
      if (cs_active && spi_sck != pol) run++;
      else if (run > 0) begin
        if (run != run_exp) bad_run++;
        run = 0;
      end
      if (frame_done) done_k = k;
      if (poke && k == 3) begin start = 1'b1; cfg_word = ~c; end
      else begin start = 1'b0; cfg_word = c; end
      @(negedge clk);
      k++;
    end
    start = 1'b0; cfg_word = c;
    chk(cs_cnt == total, "R4 select length", cs_cnt, total);
    chk(first_edge == fe_exp, "R3/R2 first edge position", first_edge, fe_exp);
    chk(nsamp == n, "R5 sample strobes", nsamp, n);
    chk(nshift == n, "R5 shift strobes", nshift, n);
    chk(bad_pol == 0, "R7 sample edge direction", bad_pol, 0);
    chk(bad_run == 0, "R2 active half length", bad_run, 0);
    chk(done_k == total, "R8 done position", done_k, total);
    chk(cs_active == 1'b0 && frame_done == 1'b0, "R9/R8 no restart after done",
        {cs_active, frame_done}, 0);
    chk(spi_sck == pol, "R6 idle level after frame", spi_sck, pol);
  endtask

  initial begin
    logic [30:0] c;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({cs_active, spi_sck, sample_stb, shift_stb, frame_done} == 5'd0,
        "R11 reset state", {cs_active, spi_sck, sample_stb, shift_stb, frame_done}, 0);

    // R1 minimum encoding, clamped frame size 0 -> 4 bits (R5)
    run_frame(31'd0, 1'b0);
    // R5 clamp boundary code 2 -> 4 bits, code 3 -> 4 bits
    run_frame(31'(4'd2) << 27, 1'b0);
    run_frame((31'(4'd3) << 27) | 31'(1) << 25, 1'b0);
    // R5 maximum 16 bits, polarity and phase high (R6, R7)
    run_frame((31'(4'd15) << 27) | (31'd1 << 26) | (31'd1 << 25) | (31'd1 << 24), 1'b0);
    // R1 long divider: prescaler 2, scaler 256
    run_frame(31'd8, 1'b0);
    // R1 prescaler 7 with scaler 6
    run_frame((31'd3 << 16) | 31'd2 | (31'd7 << 27), 1'b0);
    // R3 large lead delay 3*2^6, R4 trail 7*2^3
    run_frame((31'd1 << 22) | (31'd5 << 12) | (31'd3 << 20) | (31'd2 << 8), 1'b0);
    // R9 start and configuration change during a frame
    run_frame((31'd7 << 27) | (31'd1 << 26) | (31'd2 << 16) | 31'd1, 1'b1);
    run_frame((31'd4 << 27) | (31'd1 << 25) | (31'd1 << 16) | 31'd3, 1'b1);

    for (int i = 0; i < 40; i++) begin
      c = 31'($urandom);
      c[3:0]   = 4'($urandom % 4);
      c[15:12] = 4'($urandom % 4);
      c[11:8]  = 4'($urandom % 4);
      run_frame(c, (i % 5) == 0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule